// File: doc/BRIEF.md
# Double-Precision to Signed Word Converter

This block takes a 64-bit IEEE-754 double and produces a signed 32-bit integer. The integer sits in the low half of a 64-bit result word. The upper half carries a fixed fill pattern, so the word can go straight back into a floating-point register file. The caller pulses `start_i` with the operand and a rounding selection. One clock later the block returns the result word, a set of conversion status flags and a write-enable for the destination.

Rounding follows a 2-bit selector. A truncate input overrides the selector and forces rounding toward zero. When the operand cannot be represented, the block writes a fixed saturation pattern, or it raises an exception request and leaves the destination untouched. Which of the two happens depends on the invalid-operation enable. Operands that are NaN, infinite or out of range are all treated as invalid. Zeros and denormals convert quietly to zero.

Top module: `f64_to_i32_cvt`

## Requirements
- R1: `rmode_i` selects the rounding direction: 0 nearest, 1 toward zero, 2 toward plus infinity, 3 toward minus infinity. When `trunc_i` is 1, rounding is toward zero whatever `rmode_i` says.
- R2: A valid conversion writes a result word whose bits 63..32 are 0xFFF80000. Bits 31..0 hold the two's-complement integer.
- R3: In nearest mode, a value exactly halfway between two integers rounds to the even one (2.5 to 2, 3.5 to 4, -2.5 to -2, 0.5 to 0).
- R4: On a valid conversion, `frac_inexact_o` is 1 when any discarded fraction bit was non-zero. `frac_rounded_o` is 1 only when rounding increased the magnitude. An exact operand clears both.
- R5: A zero of either sign, or a denormal operand (exponent field 0), converts to 0 in every mode. Every flag is 0 for such an operand.
- R6: A NaN operand (exponent field all ones, fraction non-zero) sets `cvt_invalid_o` and `inv_summary_o` and clears both fraction flags. With the enable at 0 it writes 0xFFF8000080000000, whatever the NaN's sign.
- R7: A NaN whose fraction bit 51 is 0 also sets `snan_o`. A NaN with bit 51 at 1 leaves `snan_o` at 0.
- R8: An operand above 2^31-1 or below -2^31, before rounding and including infinities, sets `cvt_invalid_o` and `inv_summary_o` and clears both fraction flags. With the enable at 0 it writes 0xFFF800007FFFFFFF for a positive operand and 0xFFF8000080000000 for a negative one. Exactly -2^31 and 2^31-1 are valid.
- R9: With `inv_en_i` at 1, an invalid operand sets `exc_enabled_o` and pulses `exc_req_o` for one cycle. It keeps `dest_wr_o` at 0 and leaves `result_o` unchanged.
- R10: Result and flags are registered. They appear one clock after `start_i`, together with a one-cycle `valid_o`. Without a start they hold their values. `dest_wr_o` pulses with `valid_o` on every conversion that writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a conversion of `operand_i` |
| operand_i | input | 64 | IEEE-754 double operand |
| rmode_i | input | 2 | Rounding direction selector |
| trunc_i | input | 1 | Force rounding toward zero |
| inv_en_i | input | 1 | Invalid-operation exception enable |
| result_o | output | 64 | Fill pattern and integer result |
| valid_o | output | 1 | One-cycle strobe: conversion finished |
| dest_wr_o | output | 1 | One-cycle strobe: result_o was written |
| cvt_invalid_o | output | 1 | Invalid integer conversion |
| inv_summary_o | output | 1 | Invalid-operation summary |
| snan_o | output | 1 | Operand was a signalling NaN |
| frac_rounded_o | output | 1 | Magnitude was increased by rounding |
| frac_inexact_o | output | 1 | Discarded fraction was non-zero |
| exc_enabled_o | output | 1 | Invalid case occurred with the enable set |
| exc_req_o | output | 1 | One-cycle exception request |

## Verification
The range decision and the rounding decision are taken on the same operand in the same cycle. An operand within half a unit of a bound could be pushed across the bound by one of them while the other keeps it inside. The bench provokes this with operands of 2147483647.0 and 2147483647.5 under toward-zero rounding, and with -2147483648.0 and -2147483648.5. A verdict counts as correct when the saturation pattern with the invalid flags appears exactly for the operands that lie beyond the bounds before rounding, and when the rounded integer with clear invalid flags appears for the rest. A second collision, an enabled exception arriving on the cycle after an ordinary write, is judged by seeing the earlier result survive unchanged.

// File: rtl/cvt_pkg.sv
package cvt_pkg;

   localparam int unsigned DBL_W  = 64;
   localparam int unsigned EXP_W  = 11;
   localparam int unsigned FRAC_W = 52;
   localparam int unsigned BIAS   = 1023;
   localparam int unsigned MANT_W = FRAC_W + 1;

   typedef enum logic [1:0] {
      RM_NEAREST = 2'd0,
      RM_ZERO    = 2'd1,
      RM_PLUS    = 2'd2,
      RM_MINUS   = 2'd3
   } rnd_mode_e;

   typedef struct packed {
      logic is_nan;
      logic is_snan;
      logic is_tiny;
      logic is_huge;
      logic sign;
   } opnd_class_t;

   typedef struct packed {
      logic cvt_inv;
      logic inv_sum;
      logic snan;
      logic frac_rnd;
      logic frac_inx;
      logic exc_en;
   } cvt_flags_t;

endpackage

// File: rtl/cvt_classify.sv
module cvt_classify
   import cvt_pkg::*;
#(
   parameter int unsigned INT_W = 32
) (
   input  logic [DBL_W-1:0] op_i,
   output opnd_class_t      cls_o,
   output logic [6:0]       shamt_o
);

   localparam logic [EXP_W-1:0] EXP_HUGE = EXP_W'(BIAS + INT_W);
   localparam logic [EXP_W-1:0] EXP_HALF = EXP_W'(BIAS - 1);
   localparam logic [11:0]      EXP_UNIT = 12'(BIAS + FRAC_W);
   localparam logic [6:0]       SH_FLOOR = 7'(MANT_W + 1);

   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;
   logic              exp_ones;

   assign exp_f    = op_i[DBL_W-2 -: EXP_W];
   assign frac_f   = op_i[FRAC_W-1:0];
   assign exp_ones = &exp_f;

   always_comb begin
      cls_o.sign    = op_i[DBL_W-1];
      cls_o.is_nan  = exp_ones & (|frac_f);
      cls_o.is_snan = exp_ones & (|frac_f) & ~frac_f[FRAC_W-1];
      cls_o.is_tiny = (exp_f == '0);
      cls_o.is_huge = ~cls_o.is_nan & (exp_f >= EXP_HUGE);
   end

   // Right shift that leaves the integer part above bit MANT_W of the aligned word.
   always_comb begin
      if (exp_f >= EXP_HALF && exp_f < EXP_HUGE)
         shamt_o = 7'(EXP_UNIT - {1'b0, exp_f});
      else
         shamt_o = SH_FLOOR;
   end

endmodule

// File: rtl/cvt_align_round.sv
module cvt_align_round
   import cvt_pkg::*;
#(
   parameter int unsigned INT_W    = 32,
   parameter bit          TIE_EVEN = 1'b1
) (
   input  logic [FRAC_W-1:0] frac_i,
   input  logic [6:0]        shamt_i,
   input  logic              sign_i,
   input  rnd_mode_e         mode_i,
   output logic [MANT_W-1:0] ipart_o,
   output logic [INT_W-1:0]  mag_o,
   output logic              inexact_o,
   output logic              rounded_o
);

   localparam int unsigned AL_W = 2 * MANT_W;

   logic [AL_W-1:0] aligned;
   logic            guard_b;
   logic            sticky_b;
   logic            lsb_b;
   logic            near_inc;
   logic            inc;

   assign aligned   = {1'b1, frac_i, {MANT_W{1'b0}}} >> shamt_i;
   assign ipart_o   = aligned[AL_W-1:MANT_W];
   assign lsb_b     = aligned[MANT_W];
   assign guard_b   = aligned[MANT_W-1];
   assign sticky_b  = |aligned[MANT_W-2:0];
   assign inexact_o = guard_b | sticky_b;

   generate
      if (TIE_EVEN) begin : g_tie_even
         assign near_inc = guard_b & (sticky_b | lsb_b);
      end else begin : g_tie_away
         assign near_inc = guard_b;
      end
   endgenerate

   always_comb begin
      unique case (mode_i)
         RM_NEAREST: inc = near_inc;
         RM_ZERO:    inc = 1'b0;
         RM_PLUS:    inc = ~sign_i & inexact_o;
         RM_MINUS:   inc = sign_i & inexact_o;
         default:    inc = 1'b0;
      endcase
   end

   assign rounded_o = inc;
   assign mag_o     = ipart_o[INT_W-1:0] + INT_W'(inc);

endmodule

// File: rtl/cvt_pack.sv
module cvt_pack
   import cvt_pkg::*;
#(
   parameter int unsigned       INT_W      = 32,
   parameter logic [DBL_W-1:0]  UPPER_FILL = 64'hFFF8_0000_0000_0000
) (
   input  opnd_class_t       cls_i,
   input  logic [MANT_W-1:0] ipart_i,
   input  logic [INT_W-1:0]  mag_i,
   input  logic              inexact_i,
   input  logic              rounded_i,
   input  logic              inv_en_i,
   output logic [DBL_W-1:0]  word_o,
   output cvt_flags_t        flags_o,
   output logic              write_ok_o
);

   localparam logic [MANT_W-1:0] POS_LIM = MANT_W'({1'b0, {(INT_W-1){1'b1}}});
   localparam logic [MANT_W-1:0] NEG_LIM = MANT_W'({1'b1, {(INT_W-1){1'b0}}});
   localparam logic [INT_W-1:0]  SAT_POS = {1'b0, {(INT_W-1){1'b1}}};
   localparam logic [INT_W-1:0]  SAT_NEG = {1'b1, {(INT_W-1){1'b0}}};

   logic [MANT_W-1:0] lim;
   logic              beyond;
   logic              over;
   logic              invalid;
   logic              normal;
   logic [INT_W-1:0]  sval;
   logic [INT_W-1:0]  lo;

   assign lim     = cls_i.sign ? NEG_LIM : POS_LIM;
   assign beyond  = (ipart_i > lim) | ((ipart_i == lim) & inexact_i);
   assign normal  = ~cls_i.is_nan & ~cls_i.is_tiny;
   assign over    = cls_i.is_huge | (normal & beyond);
   assign invalid = cls_i.is_nan | over;
   assign sval    = cls_i.sign ? (~mag_i + INT_W'(1)) : mag_i;

   always_comb begin
      if (cls_i.is_nan)
         lo = SAT_NEG;
      else if (over)
         lo = cls_i.sign ? SAT_NEG : SAT_POS;
      else if (cls_i.is_tiny)
         lo = '0;
      else
         lo = sval;
   end

   assign word_o = {UPPER_FILL[DBL_W-1:INT_W], lo};

   always_comb begin
      flags_o.cvt_inv  = invalid;
      flags_o.inv_sum  = invalid;
      flags_o.snan     = cls_i.is_snan;
      flags_o.frac_rnd = normal & ~invalid & rounded_i;
      flags_o.frac_inx = normal & ~invalid & inexact_i;
      flags_o.exc_en   = invalid & inv_en_i;
   end

   assign write_ok_o = ~(invalid & inv_en_i);

endmodule

// File: rtl/f64_to_i32_cvt.sv
module f64_to_i32_cvt
   import cvt_pkg::*;
#(
   parameter int unsigned      INT_W      = 32,
   parameter logic [63:0]      UPPER_FILL = 64'hFFF8_0000_0000_0000,
   parameter bit               TIE_EVEN   = 1'b1
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        start_i,
   input  logic [63:0] operand_i,
   input  logic [1:0]  rmode_i,
   input  logic        trunc_i,
   input  logic        inv_en_i,
   output logic [63:0] result_o,
   output logic        valid_o,
   output logic        dest_wr_o,
   output logic        cvt_invalid_o,
   output logic        inv_summary_o,
   output logic        snan_o,
   output logic        frac_rounded_o,
   output logic        frac_inexact_o,
   output logic        exc_enabled_o,
   output logic        exc_req_o
);

   generate
      if (INT_W < 8 || INT_W > FRAC_W) begin : g_bad_width
         $error("INT_W must lie between 8 and 52");
      end
      if (UPPER_FILL[INT_W-1:0] != '0) begin : g_bad_fill
         $error("UPPER_FILL must be zero below INT_W");
      end
   endgenerate

   opnd_class_t       cls;
   logic [6:0]        shamt;
   rnd_mode_e         eff_mode;
   logic [MANT_W-1:0] ipart;
   logic [INT_W-1:0]  mag;
   logic              inexact;
   logic              rounded;
   logic [DBL_W-1:0]  word;
   cvt_flags_t        flags_d;
   cvt_flags_t        flags_q;
   logic              write_ok;

   assign eff_mode = trunc_i ? RM_ZERO : rnd_mode_e'(rmode_i);

   cvt_classify #(.INT_W(INT_W)) u_classify (
      .op_i    (operand_i),
      .cls_o   (cls),
      .shamt_o (shamt)
   );

   cvt_align_round #(.INT_W(INT_W), .TIE_EVEN(TIE_EVEN)) u_round (
      .frac_i    (operand_i[FRAC_W-1:0]),
      .shamt_i   (shamt),
      .sign_i    (cls.sign),
      .mode_i    (eff_mode),
      .ipart_o   (ipart),
      .mag_o     (mag),
      .inexact_o (inexact),
      .rounded_o (rounded)
   );

   cvt_pack #(.INT_W(INT_W), .UPPER_FILL(UPPER_FILL)) u_pack (
      .cls_i      (cls),
      .ipart_i    (ipart),
      .mag_i      (mag),
      .inexact_i  (inexact),
      .rounded_i  (rounded),
      .inv_en_i   (inv_en_i),
      .word_o     (word),
      .flags_o    (flags_d),
      .write_ok_o (write_ok)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         result_o  <= '0;
         flags_q   <= '0;
         valid_o   <= 1'b0;
         dest_wr_o <= 1'b0;
         exc_req_o <= 1'b0;
      end else begin
         valid_o   <= start_i;
         dest_wr_o <= start_i & write_ok;
         exc_req_o <= start_i & ~write_ok;
         if (start_i)
            flags_q <= flags_d;
         if (start_i && write_ok)
            result_o <= word;
      end
   end

   assign cvt_invalid_o  = flags_q.cvt_inv;
   assign inv_summary_o  = flags_q.inv_sum;
   assign snan_o         = flags_q.snan;
   assign frac_rounded_o = flags_q.frac_rnd;
   assign frac_inexact_o = flags_q.frac_inx;
   assign exc_enabled_o  = flags_q.exc_en;

endmodule

// File: rtl/cvt_checker.sv
module cvt_checker #(
   parameter int unsigned INT_W      = 32,
   parameter logic [63:0] UPPER_FILL = 64'hFFF8_0000_0000_0000
) (
   input logic        clk_i,
   input logic        rst_ni,
   input logic        start_i,
   input logic [63:0] operand_i,
   input logic        inv_en_i,
   input logic [63:0] result_o,
   input logic        valid_o,
   input logic        dest_wr_o,
   input logic        cvt_invalid_o,
   input logic        inv_summary_o,
   input logic        snan_o,
   input logic        frac_rounded_o,
   input logic        frac_inexact_o,
   input logic        exc_enabled_o,
   input logic        exc_req_o
);

   logic op_nan;
   assign op_nan = (&operand_i[62:52]) & (|operand_i[51:0]);

   p_valid_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> valid_o);

   p_valid_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !start_i |=> (!valid_o && !dest_wr_o && !exc_req_o));

   p_result_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !start_i |=> ($stable(result_o) && $stable(cvt_invalid_o) && $stable(frac_inexact_o)));

   p_upper_fill_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dest_wr_o |-> (result_o[63:INT_W] == UPPER_FILL[63:INT_W]));

   p_nan_pattern_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !inv_en_i && op_nan) |=>
         (result_o == {UPPER_FILL[63:INT_W], 1'b1, {(INT_W-1){1'b0}}}));

   p_invalid_clears_frac_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cvt_invalid_o |-> (inv_summary_o && !frac_rounded_o && !frac_inexact_o));

   p_snan_invalid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      snan_o |-> cvt_invalid_o);

   p_round_inexact_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frac_rounded_o |-> frac_inexact_o);

   p_no_write_on_exc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exc_req_o |-> (!dest_wr_o && valid_o && exc_enabled_o && cvt_invalid_o));

   p_keep_result_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && inv_en_i && op_nan) |=> ($stable(result_o) && exc_req_o));

endmodule

bind f64_to_i32_cvt cvt_checker #(
   .INT_W      (INT_W),
   .UPPER_FILL (UPPER_FILL)
) u_cvt_checker (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .start_i        (start_i),
   .operand_i      (operand_i),
   .inv_en_i       (inv_en_i),
   .result_o       (result_o),
   .valid_o        (valid_o),
   .dest_wr_o      (dest_wr_o),
   .cvt_invalid_o  (cvt_invalid_o),
   .inv_summary_o  (inv_summary_o),
   .snan_o         (snan_o),
   .frac_rounded_o (frac_rounded_o),
   .frac_inexact_o (frac_inexact_o),
   .exc_enabled_o  (exc_enabled_o),
   .exc_req_o      (exc_req_o)
);

// File: tb/f64_to_i32_cvt_tb_top.sv
`timescale 1ns/1ps
module f64_to_i32_cvt_tb_top;

   logic        clk;
   logic        rst_n;
   logic        start;
   logic [63:0] operand;
   logic [1:0]  rmode;
   logic        trunc;
   logic        inv_en;
   logic [63:0] result;
   logic        valid;
   logic        dest_wr;
   logic        f_inv, f_sum, f_snan, f_rnd, f_inx, f_exc, exc_req;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   localparam logic [63:0] SAT_P = 64'hFFF8_0000_7FFF_FFFF;
   localparam logic [63:0] SAT_N = 64'hFFF8_0000_8000_0000;

   f64_to_i32_cvt dut_i (
      .clk_i          (clk),
      .rst_ni         (rst_n),
      .start_i        (start),
      .operand_i      (operand),
      .rmode_i        (rmode),
      .trunc_i        (trunc),
      .inv_en_i       (inv_en),
      .result_o       (result),
      .valid_o        (valid),
      .dest_wr_o      (dest_wr),
      .cvt_invalid_o  (f_inv),
      .inv_summary_o  (f_sum),
      .snan_o         (f_snan),
      .frac_rounded_o (f_rnd),
      .frac_inexact_o (f_inx),
      .exc_enabled_o  (f_exc),
      .exc_req_o      (exc_req)
   );

   initial clk = 1'b0;
   always #2.5 clk = ~clk;

   function automatic logic [63:0] iw(input int v);
      return {32'hFFF8_0000, v[31:0]};
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // flag order: invalid, summary, snan, rounded, inexact, exc_enabled, exc_req
   function automatic logic [6:0] flg();
      return {f_inv, f_sum, f_snan, f_rnd, f_inx, f_exc, exc_req};
   endfunction

   task automatic conv(input logic [63:0] op, input logic [1:0] rm, input logic tr, input logic en);
      @(negedge clk);
      operand = op; rmode = rm; trunc = tr; inv_en = en; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic conv_chk(input string tag, input real v, input logic [1:0] rm, input logic tr,
                           input logic [63:0] exp_res, input logic [6:0] exp_flg);
      conv($realtobits(v), rm, tr, 1'b0);
      chk({tag, " result"}, result, exp_res);
      chk({tag, " flags"}, {57'd0, flg()}, {57'd0, exp_flg});
   endtask

   task automatic t_reset;
      chk("R10 reset result", result, 64'd0);
      chk("R10 reset strobes/flags", {55'd0, valid, dest_wr, flg()}, 64'd0);
   endtask

   task automatic t_nearest_ties;
      conv_chk("R3 2.5 nearest",   2.5, 2'd0, 1'b0, iw(2),  7'b0000100);
      conv_chk("R3 3.5 nearest",   3.5, 2'd0, 1'b0, iw(4),  7'b0001100);
      conv_chk("R3 -2.5 nearest", -2.5, 2'd0, 1'b0, iw(-2), 7'b0000100);
      conv_chk("R3 -3.5 nearest", -3.5, 2'd0, 1'b0, iw(-4), 7'b0001100);
      conv_chk("R3 0.5 nearest",   0.5, 2'd0, 1'b0, iw(0),  7'b0000100);
      conv_chk("R3 2.6 nearest",   2.6, 2'd0, 1'b0, iw(3),  7'b0001100);
   endtask

   task automatic t_directed_modes;
      conv_chk("R1 2.3 zero",   2.3, 2'd1, 1'b0, iw(2),  7'b0000100);
      conv_chk("R1 2.3 plus",   2.3, 2'd2, 1'b0, iw(3),  7'b0001100);
      conv_chk("R1 2.3 minus",  2.3, 2'd3, 1'b0, iw(2),  7'b0000100);
      conv_chk("R1 -2.3 plus", -2.3, 2'd2, 1'b0, iw(-2), 7'b0000100);
      conv_chk("R1 -2.3 minus",-2.3, 2'd3, 1'b0, iw(-3), 7'b0001100);
      conv_chk("R1 0.3 plus",   0.3, 2'd2, 1'b0, iw(1),  7'b0001100);
   endtask

   task automatic t_truncate;
      conv_chk("R1 trunc over plus",  2.7, 2'd2, 1'b1, iw(2),  7'b0000100);
      conv_chk("R1 trunc over minus",-2.7, 2'd3, 1'b1, iw(-2), 7'b0000100);
   endtask

   task automatic t_exact;
      conv_chk("R4 R2 exact 100 plus", 100.0, 2'd2, 1'b0, iw(100), 7'b0000000);
      conv_chk("R2 exact -7",          -7.0,  2'd0, 1'b0, iw(-7),  7'b0000000);
   endtask

   task automatic t_zero_denorm;
      conv_chk("R5 +0 plus",   0.0, 2'd2, 1'b0, iw(0), 7'b0000000);
      conv($realtobits(-0.0), 2'd3, 1'b0, 1'b0);
      chk("R5 -0 minus result", result, iw(0));
      chk("R5 -0 minus flags", {57'd0, flg()}, 64'd0);
      conv(64'h0000_0000_0000_0001, 2'd2, 1'b0, 1'b0);
      chk("R5 denormal plus result", result, iw(0));
      chk("R5 denormal plus flags", {57'd0, flg()}, 64'd0);
      conv(64'h8008_0000_0000_0000, 2'd3, 1'b0, 1'b0);
      chk("R5 neg denormal minus result", result, iw(0));
      chk("R5 neg denormal minus flags", {57'd0, flg()}, 64'd0);
   endtask

   task automatic t_nan;
      conv_chk("R6 setup inexact", 1.5, 2'd2, 1'b0, iw(2), 7'b0001100);
      conv(64'h7FF8_0000_0000_0000, 2'd2, 1'b0, 1'b0);
      chk("R6 qnan result", result, SAT_N);
      chk("R6 qnan flags", {57'd0, flg()}, {57'd0, 7'b1100000});
      conv(64'hFFF8_0000_0000_0001, 2'd0, 1'b0, 1'b0);
      chk("R6 neg qnan result", result, SAT_N);
      conv(64'h7FF0_0000_0000_0001, 2'd0, 1'b0, 1'b0);
      chk("R7 snan result", result, SAT_N);
      chk("R7 snan flags", {57'd0, flg()}, {57'd0, 7'b1110000});
   endtask

   task automatic t_range;
      conv_chk("R8 2^31",            2147483648.0, 2'd0, 1'b0, SAT_P, 7'b1100000);
      conv_chk("R8 2^31-1 valid",    2147483647.0, 2'd0, 1'b0, iw(32'h7FFF_FFFF), 7'b0000000);
      conv_chk("R8 2^31-0.5 zero",   2147483647.5, 2'd1, 1'b0, SAT_P, 7'b1100000);
      conv_chk("R8 -2^31 valid",    -2147483648.0, 2'd0, 1'b0, SAT_N, 7'b0000000);
      conv_chk("R8 -2^31-0.5 zero", -2147483648.5, 2'd1, 1'b0, SAT_N, 7'b1100000);
      conv_chk("R8 1e300",           1.0e300,      2'd0, 1'b0, SAT_P, 7'b1100000);
      conv(64'h7FF0_0000_0000_0000, 2'd0, 1'b0, 1'b0);
      chk("R8 +inf result", result, SAT_P);
      conv(64'hFFF0_0000_0000_0000, 2'd0, 1'b0, 1'b0);
      chk("R8 -inf result", result, SAT_N);
      chk("R8 -inf flags", {57'd0, flg()}, {57'd0, 7'b1100000});
   endtask

   task automatic t_enabled_exc;
      conv($realtobits(7.0), 2'd0, 1'b0, 1'b1);
      chk("R9 valid op with enable", result, iw(7));
      chk("R9 valid op wr", {63'd0, dest_wr}, 64'd1);
      conv(64'h7FF8_0000_0000_0000, 2'd0, 1'b0, 1'b1);
      chk("R9 nan enabled result kept", result, iw(7));
      chk("R9 nan enabled flags", {57'd0, flg()}, {57'd0, 7'b1100011});
      chk("R9 nan enabled no write", {63'd0, dest_wr}, 64'd0);
      @(negedge clk);
      chk("R9 request one cycle", {62'd0, exc_req, valid}, 64'd0);
      conv($realtobits(3.0e9), 2'd0, 1'b0, 1'b1);
      chk("R9 range enabled result kept", result, iw(7));
      chk("R9 range enabled flags", {57'd0, flg()}, {57'd0, 7'b1100011});
   endtask

   task automatic t_timing;
      conv($realtobits(5.0), 2'd0, 1'b0, 1'b0);
      chk("R10 valid and write strobe", {62'd0, valid, dest_wr}, 64'd3);
      chk("R10 result", result, iw(5));
      @(negedge clk);
      operand = $realtobits(9.0);
      @(negedge clk);
      chk("R10 strobes drop", {62'd0, valid, dest_wr}, 64'd0);
      chk("R10 result held without start", result, iw(5));
   endtask

   initial begin
      start = 1'b0; operand = '0; rmode = '0; trunc = 1'b0; inv_en = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_nearest_ties();
      t_directed_modes();
      t_truncate();
      t_exact();
      t_zero_denorm();
      t_nan();
      t_range();
      t_enabled_exc();
      t_timing();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      #500000;
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule